// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing bytes of one instruction operand into an effective address or an immediate value. When the decoder pulses `start`, the block latches a 3-bit operand mode and the prefix byte. It then pulls the bytes that follow from the instruction fetch over a valid/ready byte channel, one byte per clock.

If the mode names base registers, the block reads them from a sixteen-entry register file through two combinational read ports. It forms the sum and, for the scaled mode, multiplies it. It then raises `done` for one cycle. While `done` is high, it presents the 64-bit result and the number of instruction bytes it consumed.

The caller adds that count to the program counter. For the indirect modes, the result is the address of the pointer, and dereferencing it is left to the caller. Fetching the final operand and writing any register back are the caller's job as well.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | immediate |
| 1 | absolute |
| 2 | zero-page |
| 3 | absolute indirect |
| 4 | zero-page indirect |
| 5 | absolute plus registers |
| 6 | zero-page plus registers |
| 7 | scaled index |

Top module: `operand_agen`

## Requirements
- R1: While reset is held and in the first cycle after it, `byte_ready` and `done` are both 0.
- R2: A `start` in the idle state is taken at that clock edge. `byte_ready` is 1 from the next cycle until the final byte handshake (`byte_valid` and `byte_ready` both 1 at an edge). `done` is high for exactly one cycle, two clock edges after that final handshake.
- R3: With F = prefix[3:2], the absolute-group modes (1, 3 and 5) read 2F+2 displacement bytes, and the zero-page-group modes (2, 4 and 6) read 2F+1 displacement bytes.
- R4: The immediate mode (0) reads 2^prefix[7:4] bytes, capped at 8 bytes when prefix[7:4] is 3 or more.
- R5: Displacement and immediate bytes arrive least significant byte first and are zero-extended to 64 bits. Modes 0 to 4 return this value unchanged.
- R6: Modes 5 and 6 read one selector byte before the displacement. The result is the displacement plus register[selector[3:0]] plus register[selector[7:4]], modulo 2^64.
- R7: When both selector nibbles are equal, that register is added only once.
- R8: Mode 7 reads a scale byte and then a selector byte, with no displacement. The result is (the register sum as in R6 and R7) times (scale+1), modulo 2^64.
- R9: `consumed` equals the number of selector and scale bytes plus the number of displacement or immediate bytes read.
- R10: Nibble value 15 selects register 15, and that register's value is added like any other.
- R11: A `start` while the block is busy, and `byte_valid` while `byte_ready` is 0, have no effect on the result, the byte count or the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one operand; taken only when idle |
| mode | input | 3 | Operand mode code |
| prefix | input | 8 | Prefix byte selecting the displacement and immediate sizes |
| byte_valid | input | 1 | Instruction byte available |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| rd_idx_a | output | 4 | Register file read index, low selector nibble |
| rd_idx_b | output | 4 | Register file read index, high selector nibble |
| rd_data_a | input | 64 | Register value at `rd_idx_a` |
| rd_data_b | input | 64 | Register value at `rd_idx_b` |
| done | output | 1 | Result valid for one cycle |
| eff_value | output | 64 | Effective address or immediate value |
| consumed | output | 4 | Instruction bytes consumed |

## Verification
The bench sweeps every prefix size field in both displacement groups and the capped immediate sizes. A wrong size would either stall the channel waiting for a byte that never comes or finish early with a short count. It drives equal selector nibbles, where a design adding the register twice returns a doubled base. It also drives nibble 15, where a design that treats 15 as "no register" drops that register's value. Scale values 0, 3 and 255 expose a missing +1 or a truncated multiplier. Stalls, a stray `start` mid-operand and bytes offered while idle show whether the block double-counts a byte or restarts.

// File: rtl/oag_pkg.sv
package oag_pkg;

    localparam int BYTE_W   = 8;
    localparam int DISP_MAX = 8;   // largest displacement or immediate, bytes
    localparam int HDR_MAX  = 2;   // largest scale + selector header, bytes

    typedef enum logic [2:0] {
        AM_IMM     = 3'd0,
        AM_ABS     = 3'd1,
        AM_ZPG     = 3'd2,
        AM_ABS_IND = 3'd3,
        AM_ZPG_IND = 3'd4,
        AM_ABS_REG = 3'd5,
        AM_ZPG_REG = 3'd6,
        AM_SCALED  = 3'd7
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_DISP,
        ST_SUM,
        ST_DONE
    } agen_state_e;

    // How many bytes of each kind the operand carries.
    typedef struct packed {
        logic [1:0] hdr_n;      // scale and selector bytes
        logic [3:0] disp_n;     // displacement or immediate bytes
        logic       has_scale;
        logic       has_regs;
    } op_plan_t;

    function automatic op_plan_t plan_of(input amode_e m, input logic [7:0] pfx);
        op_plan_t   p;
        logic [3:0] zp_n;
        logic [3:0] ab_n;
        logic [3:0] im_n;
        zp_n = {1'b0, pfx[3:2], 1'b0} + 4'd1;
        ab_n = zp_n + 4'd1;
        im_n = (pfx[7:4] >= 4'd3) ? 4'd8 : (4'd1 << pfx[5:4]);
        p = '0;
        case (m)
            AM_IMM:                 p.disp_n = im_n;
            AM_ABS, AM_ABS_IND:     p.disp_n = ab_n;
            AM_ZPG, AM_ZPG_IND:     p.disp_n = zp_n;
            AM_ABS_REG: begin
                p.hdr_n    = 2'd1;
                p.has_regs = 1'b1;
                p.disp_n   = ab_n;
            end
            AM_ZPG_REG: begin
                p.hdr_n    = 2'd1;
                p.has_regs = 1'b1;
                p.disp_n   = zp_n;
            end
            AM_SCALED: begin
                p.hdr_n     = 2'd2;
                p.has_regs  = 1'b1;
                p.has_scale = 1'b1;
            end
            default:                p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/oag_collect.sv
module oag_collect
    import oag_pkg::*;
#(
    parameter int NBYTES = DISP_MAX,
    parameter int CNT_W  = 4,
    parameter int SEL_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     take,
    input  op_plan_t                 plan,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [BYTE_W-1:0]        scale_q,
    output logic [SEL_W-1:0]         sel_q,
    output logic [NBYTES*BYTE_W-1:0] disp_q,
    output logic [CNT_W-1:0]         cnt_q,
    output logic                     at_last,
    output logic                     hdr_last
);

    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] didx;
    logic [CNT_W-1:0] cnt_nx;
    logic             in_hdr;
    logic             is_scale;

    assign total    = CNT_W'(plan.hdr_n) + CNT_W'(plan.disp_n);
    assign cnt_nx   = cnt_q + CNT_W'(1);
    assign in_hdr   = cnt_q < CNT_W'(plan.hdr_n);
    assign is_scale = plan.has_scale && (cnt_q == '0);
    assign didx     = cnt_q - CNT_W'(plan.hdr_n);
    assign at_last  = (cnt_nx == total);
    assign hdr_last = (cnt_nx == CNT_W'(plan.hdr_n));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            scale_q <= '0;
            sel_q   <= '0;
        end else if (take) begin
            cnt_q <= cnt_nx;
            if (is_scale) begin
                scale_q <= byte_in;
            end else if (in_hdr) begin
                sel_q <= byte_in[SEL_W-1:0];
            end
        end
    end

    // One lane register per displacement byte, little-endian placement.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lane_q <= '0;
            end else if (take && !in_hdr && (didx == CNT_W'(g))) begin
                lane_q <= byte_in;
            end
        end
        assign disp_q[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/oag_sum.sv
module oag_sum
    import oag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int RIDX_W = 4
) (
    input  logic [DATA_W-1:0]   disp_v,
    input  logic [2*RIDX_W-1:0] sel,
    input  logic [BYTE_W-1:0]   scale,
    input  logic                has_regs,
    input  logic                has_scale,
    input  logic [DATA_W-1:0]   rd_a,
    input  logic [DATA_W-1:0]   rd_b,
    output logic [RIDX_W-1:0]   idx_a,
    output logic [RIDX_W-1:0]   idx_b,
    output logic [DATA_W-1:0]   value
);

    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] base;

    assign idx_a = sel[RIDX_W-1:0];
    assign idx_b = sel[2*RIDX_W-1:RIDX_W];

    always_comb begin
        op_a  = has_regs ? rd_a : '0;
        op_b  = (has_regs && (idx_b != idx_a)) ? rd_b : '0;
        base  = disp_v + op_a + op_b;
        value = has_scale ? (base * DATA_W'(scale)) + base : base;
    end

endmodule

// File: rtl/operand_agen.sv
module operand_agen
    import oag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [7:0]        prefix,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic [RIDX_W-1:0] rd_idx_a,
    output logic [RIDX_W-1:0] rd_idx_b,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic              done,
    output logic [DATA_W-1:0] eff_value,
    output logic [3:0]        consumed
);

    localparam int SEL_W  = 2 * RIDX_W;
    localparam int DISP_W = DISP_MAX * BYTE_W;
    localparam int CNT_W  = 4;
    localparam int LIMIT  = HDR_MAX + DISP_MAX;

    agen_state_e       state_q;
    agen_state_e       state_nx;
    op_plan_t          plan_q;
    logic              start_ok;
    logic              take;
    logic [BYTE_W-1:0] scale_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DISP_W-1:0] disp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              at_last;
    logic              hdr_last;
    logic [DATA_W-1:0] sum_v;
    logic [DATA_W-1:0] value_q;

    assign start_ok   = (state_q == ST_IDLE) && start;
    assign byte_ready = (state_q == ST_SEL) || (state_q == ST_DISP);
    assign take       = byte_ready && byte_valid;
    assign done       = (state_q == ST_DONE);
    assign eff_value  = value_q;
    assign consumed   = cnt_q;

    oag_collect #(
        .NBYTES(DISP_MAX),
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) i_collect (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .take    (take),
        .plan    (plan_q),
        .byte_in (byte_data),
        .scale_q (scale_q),
        .sel_q   (sel_q),
        .disp_q  (disp_q),
        .cnt_q   (cnt_q),
        .at_last (at_last),
        .hdr_last(hdr_last)
    );

    oag_sum #(
        .DATA_W(DATA_W),
        .RIDX_W(RIDX_W)
    ) i_sum (
        .disp_v   (DATA_W'(disp_q)),
        .sel      (sel_q),
        .scale    (scale_q),
        .has_regs (plan_q.has_regs),
        .has_scale(plan_q.has_scale),
        .rd_a     (rd_data_a),
        .rd_b     (rd_data_b),
        .idx_a    (rd_idx_a),
        .idx_b    (rd_idx_b),
        .value    (sum_v)
    );

    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_nx = (plan_of(amode_e'(mode), prefix).hdr_n != 2'd0) ? ST_SEL : ST_DISP;
                end
            end
            ST_SEL: begin
                if (take) begin
                    if (at_last)       state_nx = ST_SUM;
                    else if (hdr_last) state_nx = ST_DISP;
                end
            end
            ST_DISP: begin
                if (take && at_last) state_nx = ST_SUM;
            end
            ST_SUM:  state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            plan_q  <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_nx;
            if (start_ok) begin
                plan_q <= plan_of(amode_e'(mode), prefix);
            end
            if (state_q == ST_SUM) begin
                value_q <= sum_v;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(byte_ready && done));

    // R2
    ready_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> byte_ready);

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (consumed != '0) && (consumed <= CNT_W'(LIMIT)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!byte_ready && !start_ok) |=> $stable(consumed));

endmodule

// File: tb/test_operand_agen.sv
module test_operand_agen;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [7:0]  prefix;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready;
    logic [3:0]  rd_idx_a;
    logic [3:0]  rd_idx_b;
    logic [63:0] rd_data_a;
    logic [63:0] rd_data_b;
    logic        done;
    logic [63:0] eff_value;
    logic [3:0]  consumed;

    logic [63:0] regs [16];
    int          checks = 0;
    int          errors = 0;

    // Reference model state
    int          phase = 0;
    int          need = 0;
    logic [2:0]  m_mode;
    logic [7:0]  m_pfx;
    logic [7:0]  got_q[$];
    logic [63:0] m_val;
    string       cur_tag = "R5";
    logic [7:0]  stim_q[$];

    always #2 clk = ~clk;

    assign rd_data_a = regs[rd_idx_a];
    assign rd_data_b = regs[rd_idx_b];

    operand_agen i_operand_agen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .prefix    (prefix),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_ready(byte_ready),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .done      (done),
        .eff_value (eff_value),
        .consumed  (consumed)
    );

    function automatic int hdr_bytes(input logic [2:0] md);
        if (md == 3'd7) return 2;
        if (md == 3'd5 || md == 3'd6) return 1;
        return 0;
    endfunction

    function automatic int body_bytes(input logic [2:0] md, input logic [7:0] pf);
        int f;
        f = int'(pf[3:2]);
        if (md == 3'd0) return (pf[7:4] >= 3) ? 8 : (1 << pf[7:4]);
        if (md == 3'd7) return 0;
        if (md == 3'd1 || md == 3'd3 || md == 3'd5) return 2 * f + 2;
        return 2 * f + 1;
    endfunction

    function automatic logic [63:0] expect_val(input logic [2:0] md);
        logic [63:0] v;
        logic [7:0]  s;
        logic [7:0]  sl;
        int          k;
        v = '0; s = '0; sl = '0;
        k = hdr_bytes(md);
        if (md == 3'd7) begin
            s  = got_q[0];
            sl = got_q[1];
        end else if (k == 1) begin
            sl = got_q[0];
        end
        for (int j = k; j < got_q.size(); j++) begin
            v = v | (64'(got_q[j]) << (8 * (j - k)));
        end
        if (k != 0) begin
            v = v + regs[sl[3:0]];
            if (sl[7:4] != sl[3:0]) v = v + regs[sl[7:4]];
        end
        if (md == 3'd7) v = v * (64'(s) + 64'd1);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model advances on the same edges the design does.
    always @(posedge clk) begin
        if (rst) begin
            phase = 0;
        end else begin
            case (phase)
                0: if (start) begin
                    m_mode = mode;
                    m_pfx  = prefix;
                    got_q.delete();
                    need   = hdr_bytes(mode) + body_bytes(mode, prefix);
                    phase  = 1;
                end
                1: if (byte_valid) begin
                    got_q.push_back(byte_data);
                    if (got_q.size() == need) phase = 2;
                end
                2: begin
                    m_val = expect_val(m_mode);
                    phase = 3;
                end
                default: phase = 0;
            endcase
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 ready", 64'(byte_ready), 64'(phase == 1));
            chk("R2 done", 64'(done), 64'(phase == 3));
            if (phase == 3) begin
                chk(cur_tag, eff_value, m_val);
                chk("R9 count", 64'(consumed), 64'(need));
            end
        end
    end

    task automatic push_le(input logic [63:0] v, input int n);
        for (int j = 0; j < n; j++) stim_q.push_back(v[8*j +: 8]);
    endtask

    // stall_mod: 0 = no gaps, else a gap every stall_mod cycles
    task automatic run_op(input string tag, input logic [2:0] md, input logic [7:0] pf,
                          input int stall_mod, input bit stray);
        int  i;
        int  cyc;
        bit  hs;
        cur_tag = tag;
        @(negedge clk);
        start  = 1'b1;
        mode   = md;
        prefix = pf;
        @(negedge clk);
        start  = 1'b0;
        mode   = 3'd7;        // R11: later mode/prefix changes are ignored
        prefix = 8'hFF;
        i = 0; cyc = 0;
        while (i < stim_q.size()) begin
            byte_valid = !(stall_mod != 0 && (cyc % stall_mod) == 1);
            byte_data  = stim_q[i];
            start      = stray && (cyc == 1);   // R11 stray start while busy
            hs         = byte_valid && byte_ready;
            @(negedge clk);
            cyc++;
            if (hs) i++;
        end
        start      = 1'b0;
        byte_valid = 1'b1;    // R11 bytes offered while not ready
        byte_data  = 8'hEE;
        repeat (3) @(negedge clk);
        byte_valid = 1'b0;
        stim_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            regs[k] = 64'hF00D_0000_0000_0000 ^ (64'(k + 1) * 64'h0101_0103_0507_0B0D);
        end
        rst = 1'b1; start = 1'b0; mode = '0; prefix = '0;
        byte_valid = 1'b0; byte_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 64'(byte_ready), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 64'(byte_ready), 64'd0);

        // R4 immediate sizes, including the cap
        push_le(64'h5A, 1);                 run_op("R4", 3'd0, 8'h00, 0, 0);
        push_le(64'hBEEF, 2);               run_op("R4", 3'd0, 8'h10, 3, 0);
        push_le(64'h1234_5678, 4);          run_op("R4", 3'd0, 8'h20, 0, 0);
        push_le(64'h8877_6655_4433_2211, 8); run_op("R4", 3'd0, 8'h30, 0, 0);
        push_le(64'hCAFE_F00D_DEAD_BEEF, 8); run_op("R4", 3'd0, 8'h70, 2, 0);

        // R3 / R5 displacement widths in both groups
        for (int f = 0; f < 4; f++) begin
            push_le(64'hA1B2_C3D4_E5F6_0718, 2 * f + 2);
            run_op("R3", 3'd1, 8'(f << 2), f, 0);
            push_le(64'h1827_3645_5463_7281, 2 * f + 1);
            run_op("R3", 3'd2, 8'(f << 2), 0, 0);
        end
        push_le(64'h0000_0000_0000_4321, 2); run_op("R5", 3'd3, 8'h00, 0, 0);
        push_le(64'h0000_0000_0099_8877, 3); run_op("R5", 3'd4, 8'h04, 0, 1);

        // R6 two registers plus displacement
        stim_q.push_back(8'h21); push_le(64'h1000, 2); run_op("R6", 3'd5, 8'h00, 0, 0);
        stim_q.push_back(8'h4A); push_le(64'h77, 1);   run_op("R6", 3'd6, 8'h00, 2, 1);
        stim_q.push_back(8'hC9); push_le(64'h0102_0304_0506, 6); run_op("R6", 3'd5, 8'h08, 0, 0);

        // R7 equal nibbles added once
        stim_q.push_back(8'h33); push_le(64'h10, 1); run_op("R7", 3'd6, 8'h00, 0, 0);

        // R10 register 15 is a real register
        stim_q.push_back(8'hF0); push_le(64'h0, 2); run_op("R10", 3'd5, 8'h00, 0, 0);
        stim_q.push_back(8'hFF); push_le(64'h5, 1); run_op("R10", 3'd6, 8'h00, 0, 0);

        // R8 scaled index
        stim_q.push_back(8'h00); stim_q.push_back(8'h12); run_op("R8", 3'd7, 8'h00, 0, 0);
        stim_q.push_back(8'h03); stim_q.push_back(8'h55); run_op("R8", 3'd7, 8'h00, 2, 1);
        stim_q.push_back(8'hFF); stim_q.push_back(8'hFE); run_op("R8", 3'd7, 8'h0C, 0, 0);

        // R11 back-to-back with a stray start
        stim_q.push_back(8'h7E); push_le(64'h0BAD, 2); run_op("R11", 3'd5, 8'h00, 3, 1);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule